// File: doc/BRIEF.md
# Snapshot Byte-Read Bus Interface

This block sits between a CPU data bus and a pair of 12-bit axis position counters plus three push buttons. The CPU pulls the active-low chip select low. It then picks an axis with `axis_sel` and a byte with `byte_sel`, and reads eight bits at a time. Every byte read during one chip-select low period comes from a single frozen copy of both counters and the button status. That copy is taken on the cycle in which the chip-select falling edge is seen. A 12-bit value therefore cannot tear between its low and high byte reads.

Chip select comes in asynchronously and passes through `SYNC_STAGES` flip-flops (default 2). A two-state machine then acts on the synchronized level:

- **ST_TRACK**: the chip is deselected. The snapshot register reloads from the live inputs on every cycle, and counter changes arm the count flag.
- **ST_HOLD**: the chip is selected. The snapshot is frozen, the bus is driven and the count flag is kept inactive.

The transitions are:

- **SELECT** (ST_TRACK to ST_HOLD): taken when the synchronized chip select is low. On this cycle the snapshot takes its last load and the count flag is cleared.
- **RELEASE** (ST_HOLD to ST_TRACK): taken when the synchronized chip select is high again.

The tri-state bus is modelled as a data output plus a separate output enable. Two active-low flags can serve as interrupt sources:

- one reports that a counter moved while the chip was deselected;
- one reports that any button is held.

Top module: `snap_rd_bus`

## Requirements
- R1: After reset, and while the chip is deselected, `bus_oe` is 0 and `bus_data` is 0. From the third rising clock edge after `cs_n` falls, `bus_oe` is 1 until the third rising edge after `cs_n` rises again.
- R2: With `axis_sel`=0 the X counter is read and with `axis_sel`=1 the Y counter is read. With `byte_sel`=0 the low byte is returned and with `byte_sel`=1 the high byte is returned.
- R3: The low byte equals count bits 7..0 of the selected axis.
- R4: The high byte holds, all active-high: bit 7 = any button pressed, bit 6 = left pressed, bit 5 = right pressed, bit 4 = middle pressed, bits 3..0 = count bits 11..8. The button inputs themselves are active-low.
- R5: While the chip stays selected, later changes on the counters or buttons do not alter the data read. Switching `axis_sel` or `byte_sel` reads other parts of the same snapshot.
- R6: A counter value present in the SELECT cycle (the third rising edge after `cs_n` falls) is part of the snapshot. That change does not set the count flag.
- R7: `sw_flag_n` is 0 in the same cycle that any of `btn_left_n`, `btn_right_n` or `btn_mid_n` is 0, and 1 otherwise.
- R8: While in ST_TRACK, a change on either counter input sampled at a rising edge drives `cnt_flag_n` to 0 after that edge. Without a change, the flag stays 1.
- R9: `cnt_flag_n` is cleared on SELECT and held at 1 throughout ST_HOLD. Counter changes made while selected do not set it after RELEASE.
- R10: During reset `cnt_flag_n` and `sw_flag_n` are 1 (with buttons released), and the block starts in ST_TRACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Asynchronous active-low chip select |
| axis_sel | input | 1 | 0 = X axis, 1 = Y axis |
| byte_sel | input | 1 | 0 = low byte, 1 = high byte |
| x_count | input | CNT_W (12) | Live X counter value |
| y_count | input | CNT_W (12) | Live Y counter value |
| btn_left_n | input | 1 | Left button, active-low |
| btn_right_n | input | 1 | Right button, active-low |
| btn_mid_n | input | 1 | Middle button, active-low |
| bus_data | output | DATA_W (8) | Read data, 0 when not driven |
| bus_oe | output | 1 | Bus drive enable (1 = driven) |
| cnt_flag_n | output | 1 | Counter-changed flag, active-low |
| sw_flag_n | output | 1 | Any-button flag, active-low |

## Verification
A state machine stuck in or skipping ST_HOLD shows up within three clocks of a chip-select edge. It appears either as a wrong `bus_oe` or as a count flag that is not forced high. A snapshot register that keeps loading while selected appears on the first byte read after the counters move. A mis-wired byte mux shows at once in the swept reads over all select combinations and button patterns. A wrong change detector or flag-arming condition shows one clock after a counter step, either as a missing flag or as a flag raised by a step in the SELECT cycle or during ST_HOLD.

// File: rtl/snap_rd_pkg.sv
package snap_rd_pkg;

    // Read-path state: deselected (tracking live values) or selected (frozen)
    typedef enum logic [0:0] {
        ST_TRACK = 1'b0,
        ST_HOLD  = 1'b1
    } rd_state_e;

    // Number of status bits in the high byte: any, left, right, middle
    localparam int unsigned STAT_W = 4;

    // Button status as reported on the bus, all active-high
    typedef struct packed {
        logic any_pressed;
        logic left;
        logic right;
        logic mid;
    } btn_stat_t;

endpackage

// File: rtl/snap_rd_sync.sv
module snap_rd_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= 1'b1;
                    else        chain_q[s] <= async_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= 1'b1;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/snap_rd_change.sv
module snap_rd_change #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] value,
    output logic         changed
);

    logic [W-1:0] prev_q;
    logic         primed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= value;
            primed_q <= 1'b1;
        end
    end

    // No event on the first cycle after reset: prev_q is not yet valid
    assign changed = primed_q && (value != prev_q);

endmodule

// File: rtl/snap_rd_mux.sv
module snap_rd_mux
    import snap_rd_pkg::*;
#(
    parameter int unsigned CNT_W  = 12,
    parameter int unsigned DATA_W = 8
) (
    input  logic [CNT_W-1:0]  cnt_x,
    input  logic [CNT_W-1:0]  cnt_y,
    input  btn_stat_t         stat,
    input  logic              axis_sel,
    input  logic              byte_sel,
    output logic [DATA_W-1:0] byte_o
);

    localparam int unsigned HI_CNT_W = CNT_W - DATA_W;

    logic [CNT_W-1:0]  cnt_sel;
    logic [DATA_W-1:0] lo_byte;
    logic [DATA_W-1:0] hi_byte;

    always_comb begin
        cnt_sel = axis_sel ? cnt_y : cnt_x;
        lo_byte = cnt_sel[DATA_W-1:0];
        hi_byte = '0;
        hi_byte[DATA_W-1 -: STAT_W] = stat;
        hi_byte[HI_CNT_W-1:0]       = cnt_sel[CNT_W-1:DATA_W];
        byte_o  = byte_sel ? hi_byte : lo_byte;
    end

endmodule

// File: rtl/snap_rd_bus.sv
module snap_rd_bus
    import snap_rd_pkg::*;
#(
    parameter int unsigned CNT_W       = 12,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              axis_sel,
    input  logic              byte_sel,
    input  logic [CNT_W-1:0]  x_count,
    input  logic [CNT_W-1:0]  y_count,
    input  logic              btn_left_n,
    input  logic              btn_right_n,
    input  logic              btn_mid_n,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_oe,
    output logic              cnt_flag_n,
    output logic              sw_flag_n
);

    localparam int unsigned NUM_AXES = 2;

    logic      cs_sync;
    rd_state_e state_q;
    rd_state_e state_d;

    logic [NUM_AXES-1:0][CNT_W-1:0] live_cnt;
    logic [NUM_AXES-1:0][CNT_W-1:0] snap_cnt_q;
    logic [NUM_AXES-1:0]            axis_changed;
    btn_stat_t                      live_stat;
    btn_stat_t                      snap_stat_q;
    logic                           flag_pend_q;
    logic [DATA_W-1:0]              mux_byte;
    logic                           select_now;

    // Chip select into the clock domain
    snap_rd_sync #(.STAGES(SYNC_STAGES)) u_cs_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(cs_n),
        .sync_out(cs_sync)
    );

    assign live_cnt[0] = x_count;
    assign live_cnt[1] = y_count;

    // One change detector per axis
    generate
        for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
            snap_rd_change #(.W(CNT_W)) u_chg (
                .clk    (clk),
                .rst_n  (rst_n),
                .value  (live_cnt[a]),
                .changed(axis_changed[a])
            );
        end
    endgenerate

    // Live button status, reported active-high
    always_comb begin
        live_stat.left        = ~btn_left_n;
        live_stat.right       = ~btn_right_n;
        live_stat.mid         = ~btn_mid_n;
        live_stat.any_pressed = ~(btn_left_n & btn_right_n & btn_mid_n);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_TRACK: if (!cs_sync) state_d = ST_HOLD;   // SELECT
            ST_HOLD:  if (cs_sync)  state_d = ST_TRACK;  // RELEASE
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_TRACK;
        else        state_q <= state_d;
    end

    assign select_now = (state_q == ST_TRACK) && !cs_sync;

    // Snapshot follows live values in ST_TRACK, including the SELECT cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_cnt_q  <= '0;
            snap_stat_q <= '0;
        end else if (state_q == ST_TRACK) begin
            snap_cnt_q  <= live_cnt;
            snap_stat_q <= live_stat;
        end
    end

    // Count flag: armed only in ST_TRACK with chip select high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_pend_q <= 1'b0;
        end else if (select_now || state_q == ST_HOLD) begin
            flag_pend_q <= 1'b0;
        end else if (|axis_changed) begin
            flag_pend_q <= 1'b1;
        end
    end

    snap_rd_mux #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_mux (
        .cnt_x   (snap_cnt_q[0]),
        .cnt_y   (snap_cnt_q[1]),
        .stat    (snap_stat_q),
        .axis_sel(axis_sel),
        .byte_sel(byte_sel),
        .byte_o  (mux_byte)
    );

    // Outputs
    always_comb begin
        bus_oe     = (state_q == ST_HOLD);
        bus_data   = bus_oe ? mux_byte : '0;
        cnt_flag_n = ~flag_pend_q;
        sw_flag_n  = ~live_stat.any_pressed;
    end

endmodule

// File: rtl/snap_rd_bus_chk.sv
module snap_rd_bus_chk #(
    parameter int unsigned CNT_W  = 12,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              axis_sel,
    input logic              byte_sel,
    input logic [CNT_W-1:0]  x_count,
    input logic [CNT_W-1:0]  y_count,
    input logic [DATA_W-1:0] bus_data,
    input logic              bus_oe,
    input logic              cnt_flag_n,
    input logic              sw_flag_n
);

    AST_FLAG_QUIET_WHILE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> cnt_flag_n); // R9

    AST_FLAG_SET_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnt_flag_n) |-> (!bus_oe && !$past(bus_oe))); // R8

    AST_FLAG_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnt_flag_n) |-> (($past(x_count) != $past(x_count, 2)) ||
                               ($past(y_count) != $past(y_count, 2)))); // R8

    AST_SNAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && $past(bus_oe) && $stable(axis_sel) && $stable(byte_sel))
            |-> $stable(bus_data)); // R5

    AST_ANY_BIT_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_oe) && byte_sel) |-> (bus_data[DATA_W-1] == !$past(sw_flag_n))); // R4

endmodule

bind snap_rd_bus snap_rd_bus_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .axis_sel  (axis_sel),
    .byte_sel  (byte_sel),
    .x_count   (x_count),
    .y_count   (y_count),
    .bus_data  (bus_data),
    .bus_oe    (bus_oe),
    .cnt_flag_n(cnt_flag_n),
    .sw_flag_n (sw_flag_n)
);

// File: tb/snap_rd_bus_tb.sv
`timescale 1ns/1ps
module snap_rd_bus_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        axis_sel = 1'b0;
    logic        byte_sel = 1'b0;
    logic [11:0] x_count = '0;
    logic [11:0] y_count = '0;
    logic        btn_left_n = 1'b1;
    logic        btn_right_n = 1'b1;
    logic        btn_mid_n = 1'b1;
    logic [7:0]  bus_data;
    logic        bus_oe;
    logic        cnt_flag_n;
    logic        sw_flag_n;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    snap_rd_bus u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .axis_sel(axis_sel),
        .byte_sel(byte_sel), .x_count(x_count), .y_count(y_count),
        .btn_left_n(btn_left_n), .btn_right_n(btn_right_n), .btn_mid_n(btn_mid_n),
        .bus_data(bus_data), .bus_oe(bus_oe), .cnt_flag_n(cnt_flag_n),
        .sw_flag_n(sw_flag_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_byte(input logic ax, input logic hb,
                                            input logic [11:0] xv, input logic [11:0] yv,
                                            input logic l, input logic r, input logic m);
        logic [11:0] c;
        c = ax ? yv : xv;
        if (!hb) return c[7:0];
        return {(l | r | m), l, r, m, c[11:8]};
    endfunction

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic select_chip();
        @(negedge clk);
        cs_n = 1'b0;
        cycles(3);
    endtask

    task automatic release_chip();
        cs_n = 1'b1;
        cycles(3);
    endtask

    task automatic set_btn(input logic [2:0] pressed);
        btn_left_n  = ~pressed[2];
        btn_right_n = ~pressed[1];
        btn_mid_n   = ~pressed[0];
    endtask

    task automatic read_all(input string req, input logic [11:0] xv, input logic [11:0] yv,
                            input logic [2:0] pr);
        for (int s = 0; s < 4; s++) begin
            axis_sel = s[1];
            byte_sel = s[0];
            #1;
            chk(req, bus_data, exp_byte(s[1], s[0], xv, yv, pr[2], pr[1], pr[0]));
        end
    endtask

    initial begin : watchdog
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [11:0] xv, yv;
        // R10: reset state
        cycles(3);
        chk("R10 oe", bus_oe, 0);
        chk("R10 data", bus_data, 0);
        chk("R10 cnt_flag", cnt_flag_n, 1);
        chk("R10 sw_flag", sw_flag_n, 1);
        rst_n = 1'b1;
        cycles(3);
        chk("R10 cnt_flag after release", cnt_flag_n, 1);

        // R7: switch flag over all button patterns
        for (int b = 0; b < 8; b++) begin
            set_btn(b[2:0]);
            #1;
            chk("R7", sw_flag_n, (b == 0));
        end
        set_btn(3'b000);

        // R1..R4: sweep counts, buttons and all four selections
        for (int p = 0; p < 8; p++) begin
            for (int b = 0; b < 8; b++) begin
                xv = (p == 0) ? 12'h000 : (p == 7) ? 12'hFFF : 12'((p * 12'h35B + 12'h0A5 + b));
                yv = (p == 0) ? 12'hFFF : (p == 7) ? 12'h000 : 12'(~xv ^ (p << 5));
                @(negedge clk);
                x_count = xv;
                y_count = yv;
                set_btn(b[2:0]);
                select_chip();
                chk("R1 oe driven", bus_oe, 1);
                read_all("R2 R3 R4", xv, yv, b[2:0]);
                release_chip();
                chk("R1 oe released", bus_oe, 0);
                chk("R1 data zero", bus_data, 0);
            end
        end
        set_btn(3'b000);

        // R5: snapshot frozen while selected
        @(negedge clk);
        x_count = 12'h123;
        y_count = 12'h456;
        select_chip();
        x_count = 12'hABC;
        y_count = 12'hDEF;
        set_btn(3'b101);
        cycles(2);
        read_all("R5", 12'h123, 12'h456, 3'b000);
        set_btn(3'b000);
        release_chip();
        cycles(2);

        // R8: X change while idle sets the flag one edge later
        chk("R8 quiet", cnt_flag_n, 1);
        x_count = 12'h200;
        cycles(1);
        chk("R8 x change", cnt_flag_n, 0);
        // R9: cleared on select, held high while selected
        select_chip();
        chk("R9 cleared", cnt_flag_n, 1);
        release_chip();
        chk("R9 after release", cnt_flag_n, 1);
        y_count = 12'h777;
        cycles(1);
        chk("R8 y change", cnt_flag_n, 0);
        select_chip();
        chk("R9 cleared y", cnt_flag_n, 1);
        release_chip();
        cycles(3);
        chk("R8 no change stays high", cnt_flag_n, 1);

        // R9: changes while selected do not set flag later
        select_chip();
        x_count = 12'h0F0;
        cycles(1);
        y_count = 12'h0E0;
        cycles(1);
        chk("R9 held high", cnt_flag_n, 1);
        release_chip();
        cycles(3);
        chk("R9 no late set", cnt_flag_n, 1);

        // R6: change in the SELECT cycle is captured and raises no flag
        cs_n = 1'b0;
        cycles(2);
        x_count = 12'h9A5;
        cycles(1);
        chk("R6 oe", bus_oe, 1);
        chk("R6 flag", cnt_flag_n, 1);
        read_all("R6 snap", 12'h9A5, 12'h0E0, 3'b000);
        release_chip();
        cycles(2);
        chk("R6 no flag after", cnt_flag_n, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule